// File: doc/BRIEF.md
# Sense Amplifier Trim Calibrator

This block finds, after each warm reset, a sense amplifier setting under which a known calibration page reads back without error. It drives an abstract amplifier through four trim fields: read mode, bitline reference current code, read voltage code and control timing trim. At every candidate setting it issues one read request to the read path and waits for the response, which carries an error-free flag. The first candidate that reads clean is kept. If none reads clean, a fixed default setting is applied and a failure flag is raised.

A small register port lets software overwrite the kept setting once calibration has finished. It can also set a lock bit. While the lock bit is set, the next warm reset skips the search and keeps the programmed setting. Two resets are used. `por_n` clears the stored setting and the lock. `rst_n` restarts the search and leaves the stored setting in place. `por_n` is always asserted together with `rst_n`.

The read request is a valid/ready stream. `rd_req_valid` stays high, with the trim outputs frozen, until `rd_req_ready` is seen high at a clock edge. Only one read is outstanding at a time. The response is a single-cycle `rsp_valid` pulse with no back-pressure, and it is only expected while a read is outstanding.

Top module: `sa_trim_cal`

## Requirements
- R1: While `rst_n` is low, `rd_req_valid`, `cal_busy` and `cal_done` are 0.
- R2: When `rst_n` is released with the lock clear, `cal_busy` is 1 from the first clock edge after release until the search ends.
- R3: Candidates are tried in ascending linear order. Timing trim is the innermost field, then read voltage, then reference current, and read mode is the outermost, each field counting from 0. The k-th request (counting from 0) carries index k = ((mode·2^IREF_W + iref)·2^VRD_W + vread)·2^TIM_W + tim. Mode runs 0 to MODE_N−1.
- R4: On the first response with `rsp_ok`=1, the requested candidate appears on the trim outputs. `cal_done` goes to 1, `cal_fail` stays 0, and no further request is made.
- R5: If every candidate fails, `cal_fail` goes to 1 and the default setting is applied. The default is mode 0, reference 4, read voltage 4, timing 1.
- R6: A request is held with stable trims until accepted. After an acceptance, `rd_req_valid` is low in the next cycle and stays low until a response arrives.
- R7: Mode codes 0, 1 and 2 are differential and codes 3 and 4 are pseudo single-ended. `sa_single_ended` is 1 exactly when `sa_mode` is 3 or more.
- R8: A `cfg_we` pulse while `cal_done` is 1 replaces the trim outputs from the next cycle, and the lock bit takes `cfg_lock`.
- R9: A warm reset with the lock set makes no request. It sets `cal_done` after one cycle, keeps the programmed setting and leaves `cal_fail` at 0.
- R10: A `cfg_we` pulse while `cal_done` is 0 has no effect on the setting or the lock.
- R11: `por_n` low clears the lock and sets the stored setting to the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears setting and lock |
| rst_n | input | 1 | Warm reset, active low, restarts calibration |
| rd_req_valid | output | 1 | Calibration read request valid |
| rd_req_ready | input | 1 | Read path accepts the request |
| rsp_valid | input | 1 | Read response pulse |
| rsp_ok | input | 1 | Response read was error-free |
| sa_mode | output | MODE_W | Read mode code |
| sa_single_ended | output | 1 | Current mode is pseudo single-ended |
| sa_iref | output | IREF_W | Bitline reference current code |
| sa_vread | output | VRD_W | Read voltage code |
| sa_tim | output | TIM_W | Control timing trim |
| cfg_we | input | 1 | Register write strobe |
| cfg_lock | input | 1 | Lock bit to write |
| cfg_mode | input | MODE_W | Mode to write |
| cfg_iref | input | IREF_W | Reference code to write |
| cfg_vread | input | VRD_W | Read voltage code to write |
| cfg_tim | input | TIM_W | Timing trim to write |
| cal_busy | output | 1 | Search in progress |
| cal_done | output | 1 | Setting settled |
| cal_fail | output | 1 | Last search found no passing setting |

## Verification
The bench builds the block with its default parameters: five modes, 3-bit reference and read voltage codes, and a 2-bit timing trim. That gives 1280 candidates, few enough for a full sweep to finish in a few thousand cycles. Both ends of the sweep are therefore reachable: a pass on the very first candidate, a pass on the last candidate (index 1279), and an exhausted sweep that falls back to the default. The read-path model derives pass regions from target settings and checks the linear index of every request. Random back-pressure on the request exercises the hold rule.

// File: rtl/sa_cal_pkg.sv
package sa_cal_pkg;
  typedef enum logic [1:0] {S_INIT, S_REQ, S_WAIT, S_DONE} cal_state_e;
  localparam int DIFF_MODE_N = 3;
endpackage

// File: rtl/sa_cal_digit.sv
module sa_cal_digit #(
  parameter int W   = 2,
  parameter int MAX = 3
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         at_max
);
  localparam logic [W-1:0] MAXV = W'(MAX);

  assign at_max = (val == MAXV);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     val <= '0;
    else if (clr)    val <= '0;
    else if (inc)    val <= at_max ? '0 : val + 1'b1;
  end
endmodule

// File: rtl/sa_sweep_ctr.sv
module sa_sweep_ctr #(
  parameter int MODE_N = 5,
  parameter int IREF_W = 3,
  parameter int VRD_W  = 3,
  parameter int TIM_W  = 2,
  localparam int MODE_W = $clog2(MODE_N)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [MODE_W-1:0] mode,
  output logic [IREF_W-1:0] iref,
  output logic [VRD_W-1:0]  vrd,
  output logic [TIM_W-1:0]  tim,
  output logic              last
);
  localparam int NDIG = 4;

  // digit 0 is innermost (timing), digit 3 outermost (mode)
  function automatic int dig_w(int k);
    case (k)
      0: return TIM_W;
      1: return VRD_W;
      2: return IREF_W;
      default: return MODE_W;
    endcase
  endfunction

  function automatic int dig_max(int k);
    case (k)
      0: return (1 << TIM_W) - 1;
      1: return (1 << VRD_W) - 1;
      2: return (1 << IREF_W) - 1;
      default: return MODE_N - 1;
    endcase
  endfunction

  logic [NDIG-1:0] inc;
  logic [NDIG-1:0] top;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [dig_w(k)-1:0] v;
    if (k == 0) begin : g_first
      assign inc[k] = adv;
    end else begin : g_chain
      assign inc[k] = inc[k-1] & top[k-1];
    end
    sa_cal_digit #(.W(dig_w(k)), .MAX(dig_max(k))) u_digit (
      .clk    (clk),
      .arst_n (arst_n),
      .clr    (clr),
      .inc    (inc[k]),
      .val    (v),
      .at_max (top[k])
    );
  end

  assign tim  = g_dig[0].v;
  assign vrd  = g_dig[1].v;
  assign iref = g_dig[2].v;
  assign mode = g_dig[3].v;
  assign last = &top;

  a_r3_inner_step: assert property (@(posedge clk) disable iff (!arst_n)
    (adv && !clr && !top[0]) |=> (tim == $past(tim) + 1'b1) && $stable(mode) && $stable(iref))
    else $error("timing trim did not step");

  a_r3_mode_range: assert property (@(posedge clk) disable iff (!arst_n)
    int'(mode) < MODE_N)
    else $error("mode code out of range");
endmodule

// File: rtl/sa_trim_store.sv
module sa_trim_store #(
  parameter int MODE_W    = 3,
  parameter int IREF_W    = 3,
  parameter int VRD_W     = 3,
  parameter int TIM_W     = 2,
  parameter int DEF_MODE  = 0,
  parameter int DEF_IREF  = 4,
  parameter int DEF_VREAD = 4,
  parameter int DEF_TIM   = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_open,
  input  logic              cfg_we,
  input  logic              cfg_lock,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [IREF_W-1:0] cfg_iref,
  input  logic [VRD_W-1:0]  cfg_vread,
  input  logic [TIM_W-1:0]  cfg_tim,
  input  logic              cal_we,
  input  logic              cal_def,
  input  logic [MODE_W-1:0] cand_mode,
  input  logic [IREF_W-1:0] cand_iref,
  input  logic [VRD_W-1:0]  cand_vread,
  input  logic [TIM_W-1:0]  cand_tim,
  output logic [MODE_W-1:0] st_mode,
  output logic [IREF_W-1:0] st_iref,
  output logic [VRD_W-1:0]  st_vread,
  output logic [TIM_W-1:0]  st_tim,
  output logic              lock
);
  localparam logic [MODE_W-1:0] D_MODE = MODE_W'(DEF_MODE);
  localparam logic [IREF_W-1:0] D_IREF = IREF_W'(DEF_IREF);
  localparam logic [VRD_W-1:0]  D_VRD  = VRD_W'(DEF_VREAD);
  localparam logic [TIM_W-1:0]  D_TIM  = TIM_W'(DEF_TIM);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_mode  <= D_MODE;
      st_iref  <= D_IREF;
      st_vread <= D_VRD;
      st_tim   <= D_TIM;
      lock     <= 1'b0;
    end else if (cal_we) begin
      st_mode  <= cal_def ? D_MODE : cand_mode;
      st_iref  <= cal_def ? D_IREF : cand_iref;
      st_vread <= cal_def ? D_VRD  : cand_vread;
      st_tim   <= cal_def ? D_TIM  : cand_tim;
    end else if (cfg_we && cfg_open) begin
      st_mode  <= cfg_mode;
      st_iref  <= cfg_iref;
      st_vread <= cfg_vread;
      st_tim   <= cfg_tim;
      lock     <= cfg_lock;
    end
  end

  a_r10_closed_write: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_we && !cfg_open && !cal_we) |=> $stable(lock) && $stable(st_mode)
      && $stable(st_iref) && $stable(st_vread) && $stable(st_tim))
    else $error("register write taken while search active");

  a_r11_por_unlock: assert property (@(posedge clk)
    !por_n |-> !lock)
    else $error("lock survived power-on reset");
endmodule

// File: rtl/sa_cal_seq.sv
module sa_cal_seq
  import sa_cal_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic lock,
  input  logic rd_req_ready,
  input  logic rsp_valid,
  input  logic rsp_ok,
  input  logic last,
  output logic ctr_clr,
  output logic ctr_adv,
  output logic rd_req_valid,
  output logic cal_busy,
  output logic cal_done,
  output logic cal_fail,
  output logic cal_we,
  output logic cal_def
);
  cal_state_e state, state_nx;
  logic       resp_in;

  assign resp_in      = (state == S_WAIT) && rsp_valid;
  assign ctr_clr      = (state == S_INIT);
  assign ctr_adv      = resp_in && !rsp_ok && !last;
  assign cal_we       = resp_in && (rsp_ok || last);
  assign cal_def      = !rsp_ok;
  assign rd_req_valid = (state == S_REQ);
  assign cal_busy     = (state == S_REQ) || (state == S_WAIT);
  assign cal_done     = (state == S_DONE);

  always_comb begin
    state_nx = state;
    case (state)
      S_INIT: state_nx = lock ? S_DONE : S_REQ;
      S_REQ:  if (rd_req_ready) state_nx = S_WAIT;
      S_WAIT: if (rsp_valid) state_nx = (rsp_ok || last) ? S_DONE : S_REQ;
      default: state_nx = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= S_INIT;
      cal_fail <= 1'b0;
    end else begin
      state <= state_nx;
      if (cal_we && cal_def) cal_fail <= 1'b1;
    end
  end

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid)
    else $error("second request before response");

  a_r4_pass_ends: assert property (@(posedge clk) disable iff (!arst_n)
    (resp_in && rsp_ok) |=> cal_done && !cal_fail && !rd_req_valid)
    else $error("passing read did not end search");

  a_r5_exhaust_fails: assert property (@(posedge clk) disable iff (!arst_n)
    (resp_in && !rsp_ok && last) |=> cal_done && cal_fail)
    else $error("exhausted sweep not flagged");

  a_r9_lock_skips: assert property (@(posedge clk) disable iff (!arst_n)
    (state == S_INIT && lock) |=> cal_done && !cal_fail)
    else $error("locked reset ran a search");
endmodule

// File: rtl/sa_trim_cal.sv
module sa_trim_cal
  import sa_cal_pkg::*;
#(
  parameter int MODE_N    = 5,
  parameter int IREF_W    = 3,
  parameter int VRD_W     = 3,
  parameter int TIM_W     = 2,
  parameter int DEF_MODE  = 0,
  parameter int DEF_IREF  = 4,
  parameter int DEF_VREAD = 4,
  parameter int DEF_TIM   = 1,
  localparam int MODE_W   = $clog2(MODE_N)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  output logic [MODE_W-1:0] sa_mode,
  output logic              sa_single_ended,
  output logic [IREF_W-1:0] sa_iref,
  output logic [VRD_W-1:0]  sa_vread,
  output logic [TIM_W-1:0]  sa_tim,
  input  logic              cfg_we,
  input  logic              cfg_lock,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [IREF_W-1:0] cfg_iref,
  input  logic [VRD_W-1:0]  cfg_vread,
  input  logic [TIM_W-1:0]  cfg_tim,
  output logic              cal_busy,
  output logic              cal_done,
  output logic              cal_fail
);
  localparam logic [MODE_W-1:0] SE_FIRST = MODE_W'(DIFF_MODE_N);

  logic              arst_n;
  logic              ctr_clr, ctr_adv, last, lock, cal_we, cal_def;
  logic [MODE_W-1:0] c_mode, s_mode;
  logic [IREF_W-1:0] c_iref, s_iref;
  logic [VRD_W-1:0]  c_vrd, s_vrd;
  logic [TIM_W-1:0]  c_tim, s_tim;

  assign arst_n = rst_n & por_n;

  sa_sweep_ctr #(.MODE_N(MODE_N), .IREF_W(IREF_W), .VRD_W(VRD_W), .TIM_W(TIM_W)) u_ctr (
    .clk (clk), .arst_n (arst_n), .clr (ctr_clr), .adv (ctr_adv),
    .mode (c_mode), .iref (c_iref), .vrd (c_vrd), .tim (c_tim), .last (last)
  );

  sa_cal_seq u_seq (
    .clk (clk), .arst_n (arst_n), .lock (lock),
    .rd_req_ready (rd_req_ready), .rsp_valid (rsp_valid), .rsp_ok (rsp_ok), .last (last),
    .ctr_clr (ctr_clr), .ctr_adv (ctr_adv), .rd_req_valid (rd_req_valid),
    .cal_busy (cal_busy), .cal_done (cal_done), .cal_fail (cal_fail),
    .cal_we (cal_we), .cal_def (cal_def)
  );

  sa_trim_store #(
    .MODE_W (MODE_W), .IREF_W (IREF_W), .VRD_W (VRD_W), .TIM_W (TIM_W),
    .DEF_MODE (DEF_MODE), .DEF_IREF (DEF_IREF), .DEF_VREAD (DEF_VREAD), .DEF_TIM (DEF_TIM)
  ) u_store (
    .clk (clk), .por_n (por_n), .cfg_open (cal_done),
    .cfg_we (cfg_we), .cfg_lock (cfg_lock), .cfg_mode (cfg_mode), .cfg_iref (cfg_iref),
    .cfg_vread (cfg_vread), .cfg_tim (cfg_tim),
    .cal_we (cal_we), .cal_def (cal_def),
    .cand_mode (c_mode), .cand_iref (c_iref), .cand_vread (c_vrd), .cand_tim (c_tim),
    .st_mode (s_mode), .st_iref (s_iref), .st_vread (s_vrd), .st_tim (s_tim), .lock (lock)
  );

  // candidate drives the amplifier while searching, stored value otherwise
  assign sa_mode         = cal_busy ? c_mode : s_mode;
  assign sa_iref         = cal_busy ? c_iref : s_iref;
  assign sa_vread        = cal_busy ? c_vrd  : s_vrd;
  assign sa_tim          = cal_busy ? c_tim  : s_tim;
  assign sa_single_ended = (sa_mode >= SE_FIRST);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !rd_req_valid && !cal_busy && !cal_done)
    else $error("activity during reset");

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(sa_mode)
      && $stable(sa_iref) && $stable(sa_vread) && $stable(sa_tim))
    else $error("request dropped or trims moved before acceptance");

  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!arst_n)
    (cal_busy && !cal_we) |=> cal_busy)
    else $error("busy dropped early");
endmodule

// File: tb/sa_trim_cal_test.sv
module sa_trim_cal_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por_n, rst_n, rd_req_valid, rd_req_ready, rsp_valid, rsp_ok;
  logic [2:0] sa_mode, sa_iref, sa_vread;
  logic [1:0] sa_tim;
  logic       sa_single_ended;
  logic       cfg_we, cfg_lock;
  logic [2:0] cfg_mode, cfg_iref, cfg_vread;
  logic [1:0] cfg_tim;
  logic       cal_busy, cal_done, cal_fail;

  sa_trim_cal uut (
    .clk (clk), .por_n (por_n), .rst_n (rst_n),
    .rd_req_valid (rd_req_valid), .rd_req_ready (rd_req_ready),
    .rsp_valid (rsp_valid), .rsp_ok (rsp_ok),
    .sa_mode (sa_mode), .sa_single_ended (sa_single_ended), .sa_iref (sa_iref),
    .sa_vread (sa_vread), .sa_tim (sa_tim),
    .cfg_we (cfg_we), .cfg_lock (cfg_lock), .cfg_mode (cfg_mode), .cfg_iref (cfg_iref),
    .cfg_vread (cfg_vread), .cfg_tim (cfg_tim),
    .cal_busy (cal_busy), .cal_done (cal_done), .cal_fail (cal_fail)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // vector: {en, bp, mode[2:0], iref[2:0], vread[2:0], tim[1:0]}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 2'd0},
    {1'b1, 1'b0, 3'd1, 3'd2, 3'd5, 2'd3},
    {1'b1, 1'b1, 3'd3, 3'd7, 3'd0, 2'd1},
    {1'b1, 1'b0, 3'd4, 3'd7, 3'd7, 2'd3},
    {1'b1, 1'b1, 3'd2, 3'd3, 3'd1, 2'd2},
    {1'b0, 1'b1, 3'd0, 3'd0, 3'd0, 2'd0}
  };

  // read-path model state
  logic       t_en, t_bp;
  logic [2:0] t_m, t_i, t_v;
  logic [1:0] t_t;
  int         nreq, order_err, pend;
  logic       pend_ok;
  logic [7:0] lfsr;

  function automatic int lin(int m, int i, int v, int t);
    return ((m * 8 + i) * 8 + v) * 4 + t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_trims(input string req, input int m, input int i, input int v, input int t);
    chk(lin(sa_mode, sa_iref, sa_vread, sa_tim) == lin(m, i, v, t), req,
        lin(sa_mode, sa_iref, sa_vread, sa_tim), lin(m, i, v, t));
  endtask

  initial begin
    rsp_valid = 0; rsp_ok = 0; rd_req_ready = 0; pend = 0; nreq = 0; order_err = 0;
    pend_ok = 0; lfsr = 8'hA5;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (!rst_n) begin
        pend = 0; nreq = 0; order_err = 0;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin rsp_valid = 1; rsp_ok = pend_ok; end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_req_ready = t_bp ? lfsr[0] : 1'b1;
      if (rst_n && rd_req_valid && rd_req_ready) begin
        if (lin(sa_mode, sa_iref, sa_vread, sa_tim) != nreq) order_err++;
        pend_ok = t_en && sa_mode == t_m && sa_iref == t_i && sa_vread >= t_v && sa_tim >= t_t;
        pend = 2;
        nreq++;
      end
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (!cal_done && n < 40000) begin @(negedge clk); n++; end
    chk(cal_done, req, cal_done, 1);
  endtask

  task automatic cfg_write(input logic lk, input int m, input int i, input int v, input int t);
    @(negedge clk);
    cfg_lock = lk; cfg_mode = 3'(m); cfg_iref = 3'(i); cfg_vread = 3'(v); cfg_tim = 2'(t);
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic start_cal(input logic [12:0] vec);
    {t_en, t_bp, t_m, t_i, t_v, t_t} = vec;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_cal(input logic [12:0] vec);
    int em, ei, ev, et, en;
    start_cal(vec);
    @(negedge clk);
    chk(cal_busy && !cal_done, "R2 busy after release", cal_busy, 1);
    wait_done("R2 search ends");
    if (t_en) begin em = t_m; ei = t_i; ev = t_v; et = t_t; en = lin(em, ei, ev, et) + 1; end
    else begin em = 0; ei = 4; ev = 4; et = 1; en = 1280; end
    chk_trims(t_en ? "R4 first passing setting kept" : "R5 default applied", em, ei, ev, et);
    chk(cal_fail == !t_en, t_en ? "R4 no fail flag" : "R5 fail flag", cal_fail, !t_en);
    chk(nreq == en, "R4 request count", nreq, en);
    chk(order_err == 0, "R3 sweep order", order_err, 0);
    chk(sa_single_ended == (em >= 3), "R7 single-ended decode", sa_single_ended, em >= 3);
    repeat (4) @(negedge clk);
    chk(nreq == en, "R4 no further requests", nreq, en);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 0; cfg_we = 0; cfg_lock = 0;
    cfg_mode = 0; cfg_iref = 0; cfg_vread = 0; cfg_tim = 0;
    t_en = 0; t_bp = 0; t_m = 0; t_i = 0; t_v = 0; t_t = 0;
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && !cal_busy && !cal_done, "R1 quiet in reset",
        {rd_req_valid, cal_busy, cal_done}, 0);
    chk_trims("R11 default after power-on", 0, 4, 4, 1);
    por_n = 1;

    for (int k = 0; k < NV; k++) run_cal(VEC[k]);

    // R8 override after completion
    cfg_write(1'b0, 2, 1, 6, 0);
    chk_trims("R8 override applied", 2, 1, 6, 0);
    chk(sa_single_ended == 0, "R7 differential after override", sa_single_ended, 0);

    // R9 locked reset keeps setting
    cfg_write(1'b1, 4, 5, 2, 3);
    chk_trims("R8 override with lock", 4, 5, 2, 3);
    start_cal(VEC[0]);
    repeat (2) @(negedge clk);
    chk(cal_done && !cal_fail, "R9 locked reset done", {cal_done, cal_fail}, 2);
    chk(nreq == 0, "R9 no requests when locked", nreq, 0);
    chk_trims("R9 locked setting kept", 4, 5, 2, 3);

    // R10 write during search ignored
    cfg_write(1'b0, 4, 5, 2, 3);
    start_cal({1'b1, 1'b0, 3'd0, 3'd1, 3'd0, 2'd0});
    repeat (10) @(negedge clk);
    chk(cal_busy, "R10 write issued while busy", cal_busy, 1);
    cfg_write(1'b1, 4, 6, 6, 2);
    wait_done("R10 search ends");
    chk_trims("R10 busy write ignored", 0, 1, 0, 0);
    run_cal(VEC[0]);
    chk(nreq == 1, "R10 lock not taken", nreq, 1);

    // R11 power-on reset clears lock
    cfg_write(1'b1, 3, 3, 3, 3);
    @(negedge clk); por_n = 0; rst_n = 0;
    @(negedge clk);
    chk_trims("R11 power-on restores default", 0, 4, 4, 1);
    repeat (2) @(negedge clk);
    t_en = 1; t_bp = 0; t_m = 0; t_i = 0; t_v = 0; t_t = 0;
    por_n = 1; rst_n = 1;
    wait_done("R11 search ends");
    chk(nreq == 1, "R11 lock cleared so search ran", nreq, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule